// File: doc/BRIEF.md
# Multi-channel down-counting timer unit

A register-mapped block with several independent down-counters that share one interrupt line. Each channel has its own control settings (run enable, mode, prescaler division and counter width), a load register that restarts the count at once, and a background reload register that is used only when the count wraps. Software reads the live count of any channel, masks interrupts per channel, sees raw and masked pending flags, and clears them by writing ones.

A channel runs in one of three modes. In one-shot mode it flags once on reaching zero and then stays at zero. In periodic mode it reloads from its background register after zero and keeps running. In free-running mode it wraps to its all-ones value. The register interface has single-cycle write and read strobes. Read data appears on the clock edge after the read strobe.

Top module: `tmr_unit`

## Requirements
- R1: After reset every count, control field, background value, mask bit and pending flag is zero, and `irq` is low.
- R2: A write to a channel's load register (channel base + 0x0) sets its count to the written value on that same edge, masked to the counter width. The next prescaler tick decrements from there.
- R3: An enabled channel (control bit 0 set) decrements by one on each prescaler tick. A disabled channel holds its count, and writing zero to the control register stops it.
- R4: The prescaler field in control bits 5:4 divides by 1 (value 0), 16 (value 1) or 256 (values 2 and 3). The divider restarts on any load or control write. The first tick therefore falls on the 1st, 16th or 256th edge after that write.
- R5: In periodic mode (control bit 1 set, bit 2 clear), a tick at count zero reloads the background value (channel base + 0xC). Writing that register does not disturb the running count.
- R6: In one-shot mode (control bit 2 set, which overrides bit 1), the channel flags once on reaching zero and then stays at zero without further flags.
- R7: In free-running mode (control bits 1 and 2 clear), a tick at count zero wraps the count to the all-ones value of the current width.
- R8: With control bit 3 clear the counter is 16 bits wide. Loads are truncated to 16 bits and the count wraps to 0xFFFF. With bit 3 set it is 32 bits wide.
- R9: A channel's raw flag (bit n of 0x84) is set on the tick that takes the count from 1 to 0. It is also set on a tick at count 0 when no flag has been raised since the last load. The flag stays set until it is cleared.
- R10: `irq` is the OR over channels of raw flag AND mask bit, where mask register 0x80 bit n enables channel n. Register 0x88 reads raw AND mask. Writing zero to the mask disables all interrupts.
- R11: Writing 1 to bit n of 0x8C clears channel n's raw flag. Writing 0 bits to 0x8C has no effect, and 0x8C reads as zero.
- R12: A load write in the same cycle as an expiry wins. The count takes the written value, no reload happens and no flag is raised.
- R13: Channel n's registers sit at n*0x10: 0x0 load (reads the count), 0x4 count (read-only), 0x8 control (reads back bits 5:0), 0xC background reload. Shared registers sit at 0x80 and up. Address bits 1:0 must be zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W (8) | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered one edge after `rd_en` |
| irq | output | 1 | Combined masked interrupt |

## Verification
The bench builds the block with its defaults: four channels, a 32-bit counter, a 16-bit narrow width, and division steps of 16 and 256. Because the divide-by-256 step is small, the tick boundary is reachable in a few hundred cycles. Loading zero in free-running mode reaches the 32-bit and 16-bit wrap values in a single tick, without counting through the whole range. With four channels, the per-channel mask and clear bits can be checked on distinct channels, and each test uses its own.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int DATA_W = 32;
  localparam int CTRL_W = 6;

  typedef enum logic [1:0] {
    CR_LOAD  = 2'd0,
    CR_VALUE = 2'd1,
    CR_CTRL  = 2'd2,
    CR_BGLD  = 2'd3
  } ch_reg_e;

  typedef enum logic [1:0] {
    SR_MASK = 2'd0,
    SR_RAW  = 2'd1,
    SR_MIS  = 2'd2,
    SR_CLR  = 2'd3
  } sh_reg_e;

  typedef enum logic [1:0] {
    PS_DIV1   = 2'd0,
    PS_DIV16  = 2'd1,
    PS_DIV256 = 2'd2,
    PS_DIV256B = 2'd3
  } presc_e;

  typedef struct packed {
    logic [1:0] presc;
    logic       wide;
    logic       oneshot;
    logic       periodic;
    logic       enable;
  } ctrl_t;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int LOG_LO = 4,
  parameter int LOG_HI = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 restart,
  input  logic                 run,
  input  tmr_pkg::presc_e      sel,
  output logic                 tick
);
  logic [LOG_HI-1:0] div_q, div_d;

  always_comb begin
    div_d = div_q;
    if (restart)  div_d = '0;
    else if (run) div_d = div_q + 1'b1;
  end

  always_comb begin
    tick = 1'b0;
    if (run && !restart) begin
      case (sel)
        tmr_pkg::PS_DIV1:  tick = 1'b1;
        tmr_pkg::PS_DIV16: tick = &div_q[LOG_LO-1:0];
        default:           tick = &div_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel #(
  parameter int CNT_W    = 32,
  parameter int NARROW_W = 16,
  parameter int LOG_LO   = 4,
  parameter int LOG_HI   = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ld_we,
  input  logic                 ctrl_we,
  input  logic                 bg_we,
  input  logic [CNT_W-1:0]     wdata,
  input  tmr_pkg::ctrl_t       ctrl_in,
  output logic [CNT_W-1:0]     cnt_o,
  output tmr_pkg::ctrl_t       ctrl_o,
  output logic [CNT_W-1:0]     bg_o,
  output logic                 expire_o
);
  localparam logic [CNT_W-1:0] NARROW_MASK = CNT_W'({NARROW_W{1'b1}});

  tmr_pkg::ctrl_t   ctrl_q, ctrl_d;
  logic [CNT_W-1:0] bg_q, bg_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             fired_q, fired_d;
  logic [CNT_W-1:0] wmask;
  logic             tick;
  logic             expire;

  assign wmask = ctrl_q.wide ? {CNT_W{1'b1}} : NARROW_MASK;

  tmr_prescale #(.LOG_LO(LOG_LO), .LOG_HI(LOG_HI)) i_presc (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (ld_we | ctrl_we),
    .run     (ctrl_q.enable),
    .sel     (tmr_pkg::presc_e'(ctrl_q.presc)),
    .tick    (tick)
  );

  always_comb begin
    ctrl_d = ctrl_we ? ctrl_in : ctrl_q;
    bg_d   = bg_we   ? wdata   : bg_q;
  end

  always_comb begin
    cnt_d   = cnt_q;
    fired_d = fired_q;
    expire  = 1'b0;
    if (ld_we) begin
      cnt_d   = wdata & wmask;
      fired_d = 1'b0;
    end else if (tick) begin
      if (cnt_q == CNT_W'(1)) begin
        cnt_d   = '0;
        expire  = 1'b1;
        fired_d = 1'b1;
      end else if (cnt_q == '0) begin
        expire = !fired_q;
        if (ctrl_q.oneshot) begin
          fired_d = 1'b1;
        end else if (ctrl_q.periodic) begin
          cnt_d   = bg_q & wmask;
          fired_d = 1'b0;
        end else begin
          cnt_d   = wmask;
          fired_d = 1'b0;
        end
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      bg_q    <= '0;
      cnt_q   <= '0;
      fired_q <= 1'b0;
    end else begin
      ctrl_q  <= ctrl_d;
      bg_q    <= bg_d;
      cnt_q   <= cnt_d;
      fired_q <= fired_d;
    end
  end

  assign cnt_o    = cnt_q;
  assign ctrl_o   = ctrl_q;
  assign bg_o     = bg_q;
  assign expire_o = expire;

  // R2: a load write lands on the same edge
  p_load_now_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ld_we |=> cnt_q == ($past(wdata) & $past(wmask)));

  // R3: a stopped channel without load keeps its count
  p_hold_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q.enable && !ld_we) |=> $stable(cnt_q));

  // R5: periodic wrap takes the background value
  p_periodic_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !ld_we && cnt_q == '0 && ctrl_q.periodic && !ctrl_q.oneshot)
      |=> cnt_q == $past(bg_q & wmask));

  // R6: a finished one-shot channel stays parked and silent
  p_oneshot_park_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.oneshot && fired_q && cnt_q == '0 && !ld_we && !ctrl_we)
      |=> cnt_q == '0);
  p_oneshot_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.oneshot && fired_q && cnt_q == '0) |-> !expire_o);
endmodule

// File: rtl/tmr_irq.sv
module tmr_irq #(
  parameter int NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] expire,
  input  logic              mask_we,
  input  logic              clr_we,
  input  logic [NUM_CH-1:0] wdata,
  output logic [NUM_CH-1:0] mask_o,
  output logic [NUM_CH-1:0] raw_o,
  output logic              irq_o
);
  logic [NUM_CH-1:0] mask_q, mask_d;
  logic [NUM_CH-1:0] raw_q, raw_d;
  logic [NUM_CH-1:0] clr_bits;

  always_comb begin
    clr_bits = clr_we ? wdata : '0;
    mask_d   = mask_we ? wdata : mask_q;
    raw_d    = (raw_q & ~clr_bits) | expire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      raw_q  <= '0;
    end else begin
      mask_q <= mask_d;
      raw_q  <= raw_d;
    end
  end

  assign mask_o = mask_q;
  assign raw_o  = raw_q;
  assign irq_o  = |(raw_q & mask_q);

  // R10: an all-zero mask write silences the line
  p_mask_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_we && wdata == '0) |=> !irq_o);

  // R11: cleared bits drop unless a new expiry arrives
  p_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we |=> (raw_q & $past(wdata & ~expire)) == '0);

  // R9: pending flags are sticky without a clear
  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_we |=> (raw_q & $past(raw_q)) == $past(raw_q));
endmodule

// File: rtl/tmr_unit.sv
module tmr_unit #(
  parameter int NUM_CH   = 4,
  parameter int ADDR_W   = 8,
  parameter int CNT_W    = 32,
  parameter int NARROW_W = 16,
  parameter int LOG_LO   = 4,
  parameter int LOG_HI   = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic                       rd_en,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [tmr_pkg::DATA_W-1:0] wdata,
  output logic [tmr_pkg::DATA_W-1:0] rdata,
  output logic                       irq
);
  import tmr_pkg::*;

  localparam int IDX_W = ADDR_W - 5;

  logic             aligned;
  logic             shared_sel;
  logic [IDX_W-1:0] idx;
  logic [1:0]       reg_sel;

  logic [CNT_W-1:0] cnt_a  [NUM_CH];
  logic [CNT_W-1:0] bg_a   [NUM_CH];
  ctrl_t            ctrl_a [NUM_CH];
  logic [NUM_CH-1:0] expire;
  logic [NUM_CH-1:0] mask, raw;

  logic [DATA_W-1:0] rd_d, rd_q;

  assign aligned    = (addr[1:0] == 2'b00);
  assign idx        = addr[ADDR_W-2:4];
  assign reg_sel    = addr[3:2];
  assign shared_sel = addr[ADDR_W-1] && (idx == '0) && aligned;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic hit;
    assign hit = wr_en && aligned && !addr[ADDR_W-1] && (idx == IDX_W'(g));

    tmr_channel #(
      .CNT_W(CNT_W), .NARROW_W(NARROW_W), .LOG_LO(LOG_LO), .LOG_HI(LOG_HI)
    ) i_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .ld_we    (hit && ch_reg_e'(reg_sel) == CR_LOAD),
      .ctrl_we  (hit && ch_reg_e'(reg_sel) == CR_CTRL),
      .bg_we    (hit && ch_reg_e'(reg_sel) == CR_BGLD),
      .wdata    (wdata[CNT_W-1:0]),
      .ctrl_in  (ctrl_t'(wdata[CTRL_W-1:0])),
      .cnt_o    (cnt_a[g]),
      .ctrl_o   (ctrl_a[g]),
      .bg_o     (bg_a[g]),
      .expire_o (expire[g])
    );
  end

  tmr_irq #(.NUM_CH(NUM_CH)) i_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .expire  (expire),
    .mask_we (wr_en && shared_sel && sh_reg_e'(reg_sel) == SR_MASK),
    .clr_we  (wr_en && shared_sel && sh_reg_e'(reg_sel) == SR_CLR),
    .wdata   (wdata[NUM_CH-1:0]),
    .mask_o  (mask),
    .raw_o   (raw),
    .irq_o   (irq)
  );

  always_comb begin
    rd_d = '0;
    if (shared_sel) begin
      case (sh_reg_e'(reg_sel))
        SR_MASK: rd_d = DATA_W'(mask);
        SR_RAW:  rd_d = DATA_W'(raw);
        SR_MIS:  rd_d = DATA_W'(raw & mask);
        default: rd_d = '0;
      endcase
    end else if (aligned && !addr[ADDR_W-1]) begin
      for (int i = 0; i < NUM_CH; i++) begin
        if (idx == IDX_W'(i)) begin
          case (ch_reg_e'(reg_sel))
            CR_CTRL: rd_d = DATA_W'(ctrl_a[i]);
            CR_BGLD: rd_d = DATA_W'(bg_a[i]);
            default: rd_d = DATA_W'(cnt_a[i]);
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_q <= '0;
    else if (rd_en) rd_q <= rd_d;
  end

  assign rdata = rd_q;
endmodule

// File: tb/test_tmr_unit.sv
`timescale 1ns/1ps
module test_tmr_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en, rd_en;
  logic [7:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        irq;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  localparam logic [7:0] A_MASK = 8'h80, A_RAW = 8'h84, A_MIS = 8'h88, A_CLR = 8'h8C;

  tmr_unit i_tmr_unit (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  always #10 clk = ~clk;

  function automatic logic [7:0] ca(input int ch, input int off);
    return 8'(ch * 16 + off);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // tasks start and end just after a falling edge
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    d = rdata;
    rd_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    check("R1 irq", 32'(irq), 32'd0);
    rd(ca(0, 4), v); check("R1 count", v, 32'd0);
    rd(ca(1, 8), v); check("R1 ctrl", v, 32'd0);
    rd(ca(2, 12), v); check("R1 bg", v, 32'd0);
    rd(A_MASK, v);   check("R1 mask", v, 32'd0);
    rd(A_RAW, v);    check("R1 raw", v, 32'd0);
  endtask

  task automatic t_load_count();
    logic [31:0] v, w;
    wr(ca(0, 8), 32'h9);
    wr(ca(0, 0), 32'd100);
    rd(ca(0, 4), v); check("R2 load immediate", v, 32'd100);
    rd(ca(0, 4), v); check("R3 decrement", v, 32'd99);
    idle(10);
    rd(ca(0, 4), v); check("R3 steady count", v, 32'd88);
    wr(ca(0, 0), 32'd500);
    rd(ca(0, 4), v); check("R2 reload mid-run", v, 32'd500);
    wr(ca(0, 8), 32'h0);
    rd(ca(0, 4), v);
    idle(5);
    rd(ca(0, 4), w); check("R3 stopped holds", w, v);
  endtask

  task automatic t_prescale();
    logic [31:0] v;
    wr(ca(1, 8), 32'h19);
    wr(ca(1, 0), 32'd1000);
    idle(15);
    rd(ca(1, 4), v); check("R4 div16 before tick", v, 32'd1000);
    rd(ca(1, 4), v); check("R4 div16 first tick", v, 32'd999);
    wr(ca(1, 8), 32'h29);
    wr(ca(1, 0), 32'd50);
    idle(255);
    rd(ca(1, 4), v); check("R4 div256 before tick", v, 32'd50);
    rd(ca(1, 4), v); check("R4 div256 first tick", v, 32'd49);
    wr(ca(1, 8), 32'h0);
  endtask

  task automatic t_periodic();
    logic [31:0] v;
    wr(ca(2, 12), 32'd3);
    wr(ca(2, 8), 32'hB);
    wr(ca(2, 0), 32'd2);
    rd(ca(2, 4), v); check("R5 start", v, 32'd2);
    rd(ca(2, 4), v); check("R5 count", v, 32'd1);
    rd(ca(2, 4), v); check("R5 zero", v, 32'd0);
    rd(ca(2, 4), v); check("R5 reload bg", v, 32'd3);
    rd(ca(2, 4), v); check("R5 after reload", v, 32'd2);
    wr(ca(2, 12), 32'd7);
    rd(ca(2, 4), v); check("R5 bg write no disturb", v, 32'd0);
    rd(ca(2, 4), v); check("R5 new bg at wrap", v, 32'd7);
    wr(ca(2, 8), 32'h0);
    rd(A_RAW, v);  check("R9 raw set on 1->0", v, 32'h4);
    check("R10 irq masked off", 32'(irq), 32'd0);
    wr(A_MASK, 32'h4);
    check("R10 irq on with mask", 32'(irq), 32'd1);
    rd(A_MIS, v);  check("R10 masked status", v, 32'h4);
    wr(A_MASK, 32'h0);
    check("R10 zero mask", 32'(irq), 32'd0);
    wr(A_CLR, 32'h0);
    rd(A_RAW, v);  check("R11 zero clear bits", v, 32'h4);
    wr(A_CLR, 32'h4);
    rd(A_RAW, v);  check("R11 w1c", v, 32'h0);
    rd(A_CLR, v);  check("R11 clear reads zero", v, 32'h0);
  endtask

  task automatic t_oneshot();
    logic [31:0] v;
    wr(A_MASK, 32'h8);
    wr(ca(3, 8), 32'hD);
    wr(ca(3, 0), 32'd2);
    rd(ca(3, 4), v); check("R6 start", v, 32'd2);
    rd(ca(3, 4), v); check("R6 count", v, 32'd1);
    rd(ca(3, 4), v); check("R6 zero", v, 32'd0);
    check("R6 irq raised", 32'(irq), 32'd1);
    rd(A_RAW, v);    check("R6 raw once", v, 32'h8);
    wr(A_CLR, 32'h8);
    idle(5);
    rd(A_RAW, v);    check("R6 no second flag", v, 32'h0);
    rd(ca(3, 4), v); check("R6 parked at zero", v, 32'd0);
    check("R6 irq low", 32'(irq), 32'd0);
    wr(A_MASK, 32'h0);
    wr(ca(3, 8), 32'h0);
  endtask

  task automatic t_freerun();
    logic [31:0] v;
    wr(ca(0, 8), 32'h9);
    wr(ca(0, 0), 32'd0);
    rd(ca(0, 4), v); check("R7 loaded zero", v, 32'd0);
    rd(ca(0, 4), v); check("R7 wide wrap", v, 32'hFFFF_FFFF);
    rd(A_RAW, v);    check("R9 flag from loaded zero", v, 32'h1);
    wr(A_CLR, 32'h1);
    wr(ca(0, 8), 32'h1);
    wr(ca(0, 0), 32'h0001_2345);
    rd(ca(0, 4), v); check("R8 narrow load", v, 32'h0000_2345);
    wr(ca(0, 0), 32'd0);
    rd(ca(0, 4), v); check("R8 narrow zero", v, 32'd0);
    rd(ca(0, 4), v); check("R8 narrow wrap", v, 32'h0000_FFFF);
    wr(ca(0, 8), 32'h0);
    wr(A_CLR, 32'h1);
    rd(A_RAW, v);    check("R11 cleared", v, 32'h0);
  endtask

  task automatic t_priority();
    logic [31:0] v;
    wr(ca(1, 8), 32'hB);
    wr(ca(1, 12), 32'd100);
    wr(ca(1, 0), 32'd1);
    wr(ca(1, 0), 32'd40);
    rd(ca(1, 4), v); check("R12 load beats expiry", v, 32'd40);
    rd(A_RAW, v);    check("R12 no flag", v, 32'h0);
    rd(ca(1, 8), v); check("R13 ctrl readback", v, 32'hB);
    rd(ca(1, 12), v); check("R13 bg readback", v, 32'd100);
    wr(ca(1, 8), 32'h0);
  endtask

  initial begin
    #(20 * 20000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
    idle(3);
    rst_n = 1'b1;
    idle(1);
    t_reset();
    t_load_count();
    t_prescale();
    t_periodic();
    t_oneshot();
    t_freerun();
    t_priority();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule